// File: doc/BRIEF.md
# Command Effects Log Builder

This block builds a command effects log by itself and then serves it. Once reset is released it steps through every opcode slot, from 0x0000 up to the last opcode, asking an external support table whether each slot holds a supported command. Every supported opcode is appended to an on-chip log as a four-byte entry that carries the opcode and its effect flags.

When the scan is complete, the block answers two kinds of request on a single request port. A list request returns the size of the one log the block holds. A read request names a log identifier, a byte offset and a byte length. It is checked against the payload buffer size and against the log identifier. If both checks pass, the requested bytes are sent one per cycle on a byte stream. Every request receives a one-cycle response that carries a return code and a length.

Top module: `cel_log_builder`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and out_valid are 0.
- R2: A request accepted before the scan has visited every opcode slot gets return code 0x06 (busy) and rsp_len 0, and no bytes are streamed.
- R3: The log holds one entry per supported opcode, in ascending opcode order. Log byte 4k+0 and 4k+1 are the opcode of entry k (low byte first), and bytes 4k+2 and 4k+3 are its effect flags (low byte first). The flags are passed through unchanged: bit 1 is a configuration change, bit 2 a data change, bit 3 a policy change and bit 4 a log change.
- R4: A list request (req_kind 0) after the scan gets code 0x00 and rsp_len equal to 4 times the number of entries.
- R5: A read request (req_kind 1) whose offset plus length is greater than PAYLOAD_BYTES gets code 0x02 and streams nothing. This check takes priority over the identifier check. A sum exactly equal to PAYLOAD_BYTES is accepted.
- R6: A read request that is within bounds but whose identifier differs from LOG_ID gets code 0x03 and streams nothing.
- R7: A successful read gets code 0x00 and rsp_len equal to the requested length, then streams exactly that many bytes starting at the requested offset, with out_last set on the final byte. A zero length streams nothing.
- R8: Log byte positions at or beyond 4 times the entry count read as 0x00.
- R9: rsp_valid rises in the cycle after acceptance, and the first byte follows in the next cycle. req_ready stays low from acceptance until the cycle after the last byte (or after the response, when nothing is streamed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_addr | output | OP_W | Opcode slot being queried in the support table |
| tbl_hit | input | 1 | Slot at tbl_addr holds a supported command (same cycle) |
| tbl_effect | input | EFF_W | Effect flags of the slot at tbl_addr (same cycle) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when req_valid is high |
| req_kind | input | 1 | 0 = list logs, 1 = read log bytes |
| req_id | input | ID_W | Log identifier of a read request |
| req_offset | input | LEN_W | First byte of a read request |
| req_length | input | LEN_W | Byte count of a read request |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_code | output | 5 | Return code: 0x00 ok, 0x02 bad input, 0x03 unsupported, 0x06 busy |
| rsp_len | output | LEN_W | Log size (list) or bytes to follow (read) |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the stream |

## Verification
The hardest cases to reach from the ports are the edges of the byte range. One is a read that starts inside the live log and runs past the last entry into zero bytes. Another is a read whose end lands exactly on the payload buffer limit, and another is the same read pushed one byte further. The bench models a sparse support table with six scattered opcodes, so the live log is much shorter than the buffer, and it aims offsets and lengths at those two boundaries. The busy window is reached by issuing requests in the first cycles after reset, long before the full opcode sweep is complete. The bounds-over-identifier priority is reached by sending a read that violates both checks.

// File: rtl/cel_pkg.sv
package cel_pkg;
   typedef enum logic [4:0] {
      RC_OK          = 5'h00,
      RC_BAD_INPUT   = 5'h02,
      RC_UNSUPPORTED = 5'h03,
      RC_BUSY        = 5'h06
   } rc_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RESP   = 2'd1,
      ST_STREAM = 2'd2
   } ctl_state_e;

   localparam logic KIND_LIST = 1'b0;
   localparam logic KIND_READ = 1'b1;
endpackage

// File: rtl/cel_scanner.sv
// Sweeps every opcode slot once after reset and appends supported ones.
module cel_scanner #(
   parameter int OP_W        = 16,
   parameter int EFF_W       = 16,
   parameter int MAX_ENTRIES = 16,
   parameter int CNT_W       = $clog2(MAX_ENTRIES + 1),
   parameter int ENTRY_W     = OP_W + EFF_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   output logic [OP_W-1:0]                tbl_addr,
   input  logic                           tbl_hit,
   input  logic [EFF_W-1:0]               tbl_effect,
   output logic                           scan_done,
   output logic [CNT_W-1:0]               entry_count,
   output logic [MAX_ENTRIES*ENTRY_W-1:0] log_flat
);
   logic [OP_W:0]    cursor_q;
   logic [CNT_W-1:0] count_q;
   logic             append;

   assign tbl_addr    = cursor_q[OP_W-1:0];
   assign scan_done   = cursor_q[OP_W];
   assign entry_count = count_q;
   assign append      = !cursor_q[OP_W] && tbl_hit && (count_q < CNT_W'(MAX_ENTRIES));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cursor_q <= '0;
         count_q  <= '0;
      end else if (!cursor_q[OP_W]) begin
         cursor_q <= cursor_q + 1'b1;
         if (append) count_q <= count_q + 1'b1;
      end
   end

   // One register per log slot; the slot equal to the running count takes the write.
   for (genvar g = 0; g < MAX_ENTRIES; g++) begin : g_slot
      logic [ENTRY_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (append && (count_q == CNT_W'(g)))
            word_q <= {tbl_effect, cursor_q[OP_W-1:0]};
      end
      assign log_flat[g*ENTRY_W +: ENTRY_W] = word_q;
   end
endmodule

// File: rtl/cel_byte_sel.sv
// Picks one log byte by byte index; positions past the live entries read zero.
module cel_byte_sel #(
   parameter int MAX_ENTRIES = 16,
   parameter int ENTRY_W     = 32,
   parameter int LEN_W       = 16,
   parameter int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
   input  logic [MAX_ENTRIES*ENTRY_W-1:0] log_flat,
   input  logic [CNT_W-1:0]               entry_count,
   input  logic [LEN_W-1:0]               byte_idx,
   output logic [7:0]                     byte_out
);
   localparam int ENTRY_BYTES = ENTRY_W / 8;
   localparam int LOG_BYTES   = MAX_ENTRIES * ENTRY_BYTES;
   localparam int IDX_W       = $clog2(LOG_BYTES);

   logic [7:0]       bytes_a [LOG_BYTES];
   logic [LEN_W-1:0] live_bytes;

   for (genvar k = 0; k < LOG_BYTES; k++) begin : g_byte
      assign bytes_a[k] = log_flat[k*8 +: 8];
   end

   assign live_bytes = LEN_W'(entry_count) * LEN_W'(ENTRY_BYTES);

   always_comb begin
      if (byte_idx < live_bytes)
         byte_out = bytes_a[byte_idx[IDX_W-1:0]];
      else
         byte_out = 8'h00;
   end
endmodule

// File: rtl/cel_req_ctrl.sv
// Accepts list/read requests, decides the return code, then streams bytes.
module cel_req_ctrl
   import cel_pkg::*;
#(
   parameter int                LEN_W         = 16,
   parameter int                ID_W          = 128,
   parameter logic [ID_W-1:0]   LOG_ID        = '0,
   parameter int                PAYLOAD_BYTES = 64,
   parameter int                ENTRY_BYTES   = 4,
   parameter int                CNT_W         = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_done,
   input  logic [CNT_W-1:0] entry_count,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_kind,
   input  logic [ID_W-1:0]  req_id,
   input  logic [LEN_W-1:0] req_offset,
   input  logic [LEN_W-1:0] req_length,
   output logic             rsp_valid,
   output logic [4:0]       rsp_code,
   output logic [LEN_W-1:0] rsp_len,
   output logic             out_valid,
   output logic             out_last,
   output logic [LEN_W-1:0] rd_idx
);
   ctl_state_e       state_q;
   logic [4:0]       code_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] ptr_q;
   logic [LEN_W-1:0] remain_q;
   logic             accept;
   logic [LEN_W:0]   span_end;
   logic             in_bounds;
   logic [4:0]       code_d;
   logic [LEN_W-1:0] len_d;

   assign accept    = req_valid && (state_q == ST_IDLE);
   assign span_end  = {1'b0, req_offset} + {1'b0, req_length};
   assign in_bounds = span_end <= (LEN_W+1)'(PAYLOAD_BYTES);

   // Busy first, then bounds, then identifier.
   always_comb begin
      code_d = RC_OK;
      len_d  = '0;
      if (!scan_done) begin
         code_d = RC_BUSY;
      end else if (req_kind == KIND_LIST) begin
         len_d = LEN_W'(entry_count) * LEN_W'(ENTRY_BYTES);
      end else if (!in_bounds) begin
         code_d = RC_BAD_INPUT;
      end else if (req_id != LOG_ID) begin
         code_d = RC_UNSUPPORTED;
      end else begin
         len_d = req_length;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         code_q   <= RC_OK;
         len_q    <= '0;
         ptr_q    <= '0;
         remain_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               state_q  <= ST_RESP;
               code_q   <= code_d;
               len_q    <= len_d;
               ptr_q    <= req_offset;
               remain_q <= (req_kind == KIND_READ) ? len_d : '0;
            end
            ST_RESP:
               state_q <= (remain_q != '0) ? ST_STREAM : ST_IDLE;
            ST_STREAM: begin
               ptr_q    <= ptr_q + 1'b1;
               remain_q <= remain_q - 1'b1;
               if (remain_q == LEN_W'(1)) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_valid = (state_q == ST_RESP);
   assign rsp_code  = code_q;
   assign rsp_len   = len_q;
   assign out_valid = (state_q == ST_STREAM);
   assign out_last  = (state_q == ST_STREAM) && (remain_q == LEN_W'(1));
   assign rd_idx    = ptr_q;
endmodule

// File: rtl/cel_log_builder.sv
module cel_log_builder #(
   parameter int              OP_W          = 16,
   parameter int              EFF_W         = 16,
   parameter int              MAX_ENTRIES   = 16,
   parameter int              PAYLOAD_BYTES = 64,
   parameter int              LEN_W         = 16,
   parameter int              ID_W          = 128,
   parameter logic [ID_W-1:0] LOG_ID        = 128'h6c1f_3a9e_0b47_4d25_9e81_c2f0_57a6_d314
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OP_W-1:0]  tbl_addr,
   input  logic             tbl_hit,
   input  logic [EFF_W-1:0] tbl_effect,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_kind,
   input  logic [ID_W-1:0]  req_id,
   input  logic [LEN_W-1:0] req_offset,
   input  logic [LEN_W-1:0] req_length,
   output logic             rsp_valid,
   output logic [4:0]       rsp_code,
   output logic [LEN_W-1:0] rsp_len,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic             out_last
);
   localparam int ENTRY_W     = OP_W + EFF_W;
   localparam int ENTRY_BYTES = ENTRY_W / 8;
   localparam int LOG_BYTES   = MAX_ENTRIES * ENTRY_BYTES;
   localparam int CNT_W       = $clog2(MAX_ENTRIES + 1);

   if ((OP_W % 8) != 0 || (EFF_W % 8) != 0) begin : g_chk_bytes
      $error("opcode and effect widths must be whole bytes");
   end
   if (MAX_ENTRIES < 2) begin : g_chk_depth
      $error("log needs at least two entries");
   end
   if (PAYLOAD_BYTES >= (1 << LEN_W) || LOG_BYTES >= (1 << LEN_W)) begin : g_chk_len
      $error("LEN_W too narrow for the buffer or log");
   end

   logic                           scan_done;
   logic [CNT_W-1:0]               entry_count;
   logic [MAX_ENTRIES*ENTRY_W-1:0] log_flat;
   logic [LEN_W-1:0]               rd_idx;

   cel_scanner #(
      .OP_W(OP_W), .EFF_W(EFF_W), .MAX_ENTRIES(MAX_ENTRIES),
      .CNT_W(CNT_W), .ENTRY_W(ENTRY_W)
   ) u_scan (
      .clk(clk), .rst_n(rst_n),
      .tbl_addr(tbl_addr), .tbl_hit(tbl_hit), .tbl_effect(tbl_effect),
      .scan_done(scan_done), .entry_count(entry_count), .log_flat(log_flat)
   );

   cel_req_ctrl #(
      .LEN_W(LEN_W), .ID_W(ID_W), .LOG_ID(LOG_ID),
      .PAYLOAD_BYTES(PAYLOAD_BYTES), .ENTRY_BYTES(ENTRY_BYTES), .CNT_W(CNT_W)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .scan_done(scan_done), .entry_count(entry_count),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_id(req_id), .req_offset(req_offset), .req_length(req_length),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_len(rsp_len),
      .out_valid(out_valid), .out_last(out_last), .rd_idx(rd_idx)
   );

   cel_byte_sel #(
      .MAX_ENTRIES(MAX_ENTRIES), .ENTRY_W(ENTRY_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
   ) u_sel (
      .log_flat(log_flat), .entry_count(entry_count),
      .byte_idx(rd_idx), .byte_out(out_data)
   );
endmodule

// File: rtl/cel_log_builder_chk.sv
module cel_log_builder_chk #(
   parameter int LEN_W         = 16,
   parameter int PAYLOAD_BYTES = 64,
   parameter int ENTRY_BYTES   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             req_kind,
   input logic [LEN_W-1:0] req_offset,
   input logic [LEN_W-1:0] req_length,
   input logic             rsp_valid,
   input logic [4:0]       rsp_code,
   input logic [LEN_W-1:0] rsp_len,
   input logic             out_valid,
   input logic             out_last
);
   logic           took;
   logic [LEN_W:0] span;
   assign took = req_valid && req_ready;
   assign span = {1'b0, req_offset} + {1'b0, req_length};

   a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      took |=> rsp_valid);

   a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || out_valid) |-> !req_ready);

   a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !out_valid);

   a_r2_busy_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == 5'h06) |-> (rsp_len == '0));

   a_r5_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (took && req_kind && span > (LEN_W+1)'(PAYLOAD_BYTES))
      |=> (rsp_code == 5'h02 || rsp_code == 5'h06));

   a_r6_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code != 5'h00) |=> !out_valid);

   a_r4_size_multiple: assert property (@(posedge clk) disable iff (!rst_n)
      (took && !req_kind) |=> ((rsp_len % LEN_W'(ENTRY_BYTES)) == '0));

   a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |=> !out_valid);

   a_r7_stream_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == 5'h00 && rsp_len != '0 && $past(req_kind))
      |=> out_valid);
endmodule

bind cel_log_builder cel_log_builder_chk #(
   .LEN_W(LEN_W), .PAYLOAD_BYTES(PAYLOAD_BYTES), .ENTRY_BYTES(ENTRY_BYTES)
) u_chk (.*);

// File: tb/cel_log_builder_bench.sv
module cel_log_builder_bench;
   localparam int           NSUP   = 6;
   localparam int           PAYLD  = 64;
   localparam logic [127:0] GOOD_ID = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
   localparam logic [127:0] BAD_ID  = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3211;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tbl_addr;
   logic        tbl_hit;
   logic [15:0] tbl_effect;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_kind = 1'b0;
   logic [127:0] req_id = '0;
   logic [15:0] req_offset = '0;
   logic [15:0] req_length = '0;
   logic        rsp_valid;
   logic [4:0]  rsp_code;
   logic [15:0] rsp_len;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_last;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // Sparse support table: ascending opcodes with effect flags.
   logic [15:0] sup_op [NSUP] = '{16'h0100, 16'h0101, 16'h0203, 16'h4000, 16'h41FF, 16'hFFFF};
   logic [15:0] sup_ef [NSUP] = '{16'h0000, 16'h0010, 16'h0002, 16'h0000, 16'h0006, 16'h0008};

   always #4 clk = ~clk;

   always_comb begin
      tbl_hit    = 1'b0;
      tbl_effect = 16'h0000;
      for (int i = 0; i < NSUP; i++)
         if (tbl_addr == sup_op[i]) begin
            tbl_hit    = 1'b1;
            tbl_effect = sup_ef[i];
         end
   end

   cel_log_builder #(.PAYLOAD_BYTES(PAYLD), .LOG_ID(GOOD_ID)) u_cel_log_builder (
      .clk(clk), .rst_n(rst_n),
      .tbl_addr(tbl_addr), .tbl_hit(tbl_hit), .tbl_effect(tbl_effect),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_id(req_id), .req_offset(req_offset), .req_length(req_length),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_len(rsp_len),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
   );

   function automatic logic [7:0] exp_byte(input int idx);
      logic [31:0] w;
      if (idx / 4 >= NSUP) return 8'h00;
      w = {sup_ef[idx/4], sup_op[idx/4]};
      return w[8*(idx%4) +: 8];
   endfunction

   task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic run_req(input string tag, input logic kind, input logic [127:0] id,
                          input int off, input int len, input logic [4:0] ecode, input int elen);
      bit streams;
      @(negedge clk);
      chk_eq({tag, " ready before R9"}, req_ready, 1);
      req_valid = 1'b1; req_kind = kind; req_id = id;
      req_offset = 16'(off); req_length = 16'(len);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk_eq({tag, " rsp_valid R9"}, rsp_valid, 1);
      chk_eq({tag, " ready low R9"}, req_ready, 0);
      chk_eq({tag, " code"}, rsp_code, ecode);
      chk_eq({tag, " len"}, rsp_len, 16'(elen));
      streams = (ecode == 5'h00) && kind && (elen > 0);
      if (streams)
         for (int i = 0; i < elen; i++) begin
            @(negedge clk);
            chk_eq($sformatf("%s out_valid byte %0d", tag, i), out_valid, 1);
            chk_eq($sformatf("%s data byte %0d", tag, i), out_data, exp_byte(off + i));
            chk_eq($sformatf("%s last byte %0d", tag, i), out_last, (i == elen - 1));
         end
      @(negedge clk);
      chk_eq({tag, " no extra byte"}, out_valid, 0);
      chk_eq({tag, " ready after R9"}, req_ready, 1);
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      chk_eq("R1 ready", req_ready, 1);
      chk_eq("R1 rsp_valid", rsp_valid, 0);
      chk_eq("R1 out_valid", out_valid, 0);
   endtask

   task automatic t_busy();
      run_req("R2 busy read", 1'b1, GOOD_ID, 0, 4, 5'h06, 0);
      run_req("R2 busy list", 1'b0, GOOD_ID, 0, 0, 5'h06, 0);
   endtask

   task automatic t_list();
      run_req("R4 list size", 1'b0, GOOD_ID, 0, 0, 5'h00, 4 * NSUP);
   endtask

   task automatic t_full_read();
      run_req("R3 R7 whole log", 1'b1, GOOD_ID, 0, 4 * NSUP, 5'h00, 4 * NSUP);
   endtask

   task automatic t_unaligned();
      run_req("R3 unaligned span", 1'b1, GOOD_ID, 6, 5, 5'h00, 5);
   endtask

   task automatic t_tail_zero();
      run_req("R8 past live entries", 1'b1, GOOD_ID, 20, 8, 5'h00, 8);
   endtask

   task automatic t_edge();
      run_req("R5 end at limit", 1'b1, GOOD_ID, PAYLD - 4, 4, 5'h00, 4);
      run_req("R5 one past limit", 1'b1, GOOD_ID, PAYLD - 3, 4, 5'h02, 0);
   endtask

   task automatic t_bad_id();
      run_req("R6 wrong id", 1'b1, BAD_ID, 0, 4, 5'h03, 0);
      run_req("R5 bounds beats id", 1'b1, BAD_ID, PAYLD, 1, 5'h02, 0);
   endtask

   task automatic t_zero_len();
      run_req("R7 zero length", 1'b1, GOOD_ID, 5, 0, 5'h00, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset_state();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_busy();
      repeat (65536 + 8) @(posedge clk);
      t_list();
      t_full_read();
      t_unaligned();
      t_tail_zero();
      t_edge();
      t_bad_id();
      t_zero_len();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule